// File: doc/BRIEF.md
# Sixteen-Step Fractional CPU Clock Divider

This block derives a processor clock from a 32 MHz master clock. Software chooses one of sixteen speeds, from 4 MHz up to 16 MHz, by writing a 4-bit speed code to one I/O port address. The code sits in the upper four data bits of that port, and the same port reads the code back.

Many of the speeds need a divide ratio that is not a whole number, such as 6.5 or 3.75. For these the block mixes whole-cycle output periods, for example 6 and 7 master cycles, so that the long-run average matches the ratio exactly. A new code only takes effect once the current output period has finished, so the clock never shows a shortened pulse.

A flag output tells neighbouring logic, such as a wait-state generator, that the selected speed is above the 4 MHz base rate.

Top module: `cpu_clk_stepper`

## Requirements
- R1: While reset is held and after it is released, `cpu_clk` is high, the speed code is 0 and `fast_mode` is 0. The first output period is 8 master cycles long, made of 4 high cycles followed by 4 low cycles.
- R2: A cycle with `io_wr`=1 and `io_addr`=0xFF loads the speed code from `io_wdata[7:4]`. A write to any other address changes neither the code, nor `fast_mode`, nor the output clock.
- R3: When `io_rd`=1 and `io_addr`=0xFF, `io_rdata` shows the code in bits 7:4 and 0 in bits 3:0. When `io_rd`=0, or the address is any other value, `io_rdata` is 0x00.
- R4: Code n sets an average period of D(n) quarter master cycles. For n = 0..15, D is 32, 28, 26, 24, 22, 20, 18, 16, 15, 14, 13, 12, 11, 10, 9, 8. This gives 4.00, 4.57, 4.92, 5.33, 5.82, 6.40, 7.11, 8.00, 8.53, 9.14, 9.85, 10.67, 11.64, 12.80, 14.22 and 16.00 MHz.
- R5: Each period's length is set by a residue r in quarter cycles. The length is L = floor((r + D)/4) master cycles, and the new residue is (r + D) mod 4. The residue restarts at 0 in the first period that uses a newly applied code.
- R6: Each output period starts with a rising edge. It is high for floor(L/2) master cycles, which is always at least 1, and low for the rest.
- R7: A code change is applied only at the boundary of an output period. The period already in progress when the code is written finishes with its old length and its old high time.
- R8: `fast_mode` is 1 exactly when the stored code is not 0. It is updated in the cycle after the port write.
- R9: Any four consecutive periods that use the same code add up to exactly D(n) master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_master | input | 1 | 32 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data; bits 7:4 carry the speed code |
| io_rdata | output | 8 | Read data; the code in bits 7:4, zero elsewhere |
| cpu_clk | output | 1 | Generated processor clock |
| fast_mode | output | 1 | High when the selected speed is above 4 MHz |

## Verification
On every cycle, the assertions check these properties:
- The output rises only at the start of a period, and the high phase is always shorter than the period length.
- The period position stays inside the period, and the applied code changes only at a period boundary.
- The read-back low nibble is zero, a write to another address leaves the code unchanged, and `fast_mode` follows the written code.

Only the bench scenarios can show the exact sequence of period lengths for each of the sixteen codes, that every four-period window adds up to D(n), and that a write made in the middle of a period leaves that period's length and high time unchanged.

// File: rtl/cpu_clk_stepper_pkg.sv
package cpu_clk_stepper_pkg;

    localparam int CODE_W = 4;
    localparam int FRAC_W = 2;               // quarter-cycle residue
    localparam int DIV_W  = 6;               // quarters, up to 32
    localparam int LEN_W  = DIV_W - FRAC_W;  // whole-cycle period length

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [FRAC_W-1:0] resid_t;
    typedef logic [LEN_W-1:0]  len_t;

    // Average period in quarter master cycles for each speed code.
    // Codes 1..7 step by half a cycle, codes 8..15 by a quarter.
    function automatic logic [DIV_W-1:0] div_quarters(input code_t code);
        logic [DIV_W-1:0] c;
        c = DIV_W'(code);
        if (code == '0)
            return DIV_W'(32);
        else if (code < code_t'(8))
            return DIV_W'(30) - (c << 1);
        else
            return DIV_W'(23) - c;
    endfunction

    typedef struct packed {
        code_t code;
        logic  fast;
    } port_state_t;

    typedef struct packed {
        code_t  act_code;
        resid_t resid;
        len_t   pos;
        len_t   len;
        len_t   hi;
        logic   clk;
    } phase_state_t;

endpackage

// File: rtl/cpu_clk_stepper_port.sv
module cpu_clk_stepper_port
    import cpu_clk_stepper_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  PORT_ADDR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output code_t             code_o,
    output logic              fast_o
);

    localparam int LOW_W = DATA_W - CODE_W;

    port_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        hit  = (io_addr == ADDR_W'(PORT_ADDR));
        st_d = st_q;
        if (io_wr && hit) begin
            st_d.code = io_wdata[DATA_W-1 -: CODE_W];
            st_d.fast = (io_wdata[DATA_W-1 -: CODE_W] != '0);
        end
        io_rdata = (io_rd && hit) ? {st_q.code, {LOW_W{1'b0}}} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{code: '0, fast: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign fast_o = st_q.fast;

    assert_low_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[LOW_W-1:0] == '0);

    assert_other_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hit) |=> $stable(code_o));

    assert_fast_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit) |=> (fast_o == ($past(io_wdata[DATA_W-1 -: CODE_W]) != '0)));

endmodule

// File: rtl/cpu_clk_stepper_period.sv
module cpu_clk_stepper_period
    import cpu_clk_stepper_pkg::*;
(
    input  code_t  code_i,
    input  resid_t resid_i,
    output len_t   len_o,
    output len_t   hi_o,
    output resid_t resid_o
);

    logic [DIV_W-1:0] sum;

    always_comb begin
        sum     = DIV_W'(resid_i) + div_quarters(code_i);
        len_o   = sum[DIV_W-1:FRAC_W];
        resid_o = sum[FRAC_W-1:0];
        hi_o    = len_o >> 1;
    end

endmodule

// File: rtl/cpu_clk_stepper_phase.sv
module cpu_clk_stepper_phase
    import cpu_clk_stepper_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code_req,
    output logic  clk_out
);

    phase_state_t st_d, st_q;
    code_t        calc_code;
    resid_t       calc_resid, resid_nx;
    len_t         len_nx, hi_nx, pos_inc;
    logic         at_end;

    cpu_clk_stepper_period u_period (
        .code_i  (calc_code),
        .resid_i (calc_resid),
        .len_o   (len_nx),
        .hi_o    (hi_nx),
        .resid_o (resid_nx)
    );

    always_comb begin
        at_end     = (st_q.pos == st_q.len - len_t'(1));
        pos_inc    = st_q.pos + len_t'(1);
        calc_code  = code_req;
        calc_resid = (code_req == st_q.act_code) ? st_q.resid : '0;
        st_d       = st_q;
        if (at_end) begin
            st_d.act_code = code_req;
            st_d.resid    = resid_nx;
            st_d.len      = len_nx;
            st_d.hi       = hi_nx;
            st_d.pos      = '0;
            st_d.clk      = 1'b1;
        end else begin
            st_d.pos = pos_inc;
            st_d.clk = (pos_inc < st_q.hi);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{act_code: '0, resid: '0, pos: '0,
                      len: len_t'(8), hi: len_t'(4), clk: 1'b1};
        else
            st_q <= st_d;
    end

    assign clk_out = st_q.clk;

    assert_pos_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pos < st_q.len) && (st_q.len >= len_t'(2)));

    assert_high_shorter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hi >= len_t'(1)) && (st_q.hi < st_q.len));

    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> (st_q.pos == '0));

    assert_switch_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act_code) |-> (st_q.pos == '0));

endmodule

// File: rtl/cpu_clk_stepper.sv
module cpu_clk_stepper
    import cpu_clk_stepper_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] PORT_ADDR = 8'hFF
) (
    input  logic              clk_master,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              cpu_clk,
    output logic              fast_mode
);

    code_t code;

    cpu_clk_stepper_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_port (
        .clk      (clk_master),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .code_o   (code),
        .fast_o   (fast_mode)
    );

    cpu_clk_stepper_phase u_phase (
        .clk      (clk_master),
        .rst_n    (rst_n),
        .code_req (code),
        .clk_out  (cpu_clk)
    );

endmodule

// File: tb/cpu_clk_stepper_bench.sv
module cpu_clk_stepper_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       cpu_clk, fast_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Speeds in units of 10 kHz, per requirement R4.
    int freq_x100 [16] = '{400, 457, 492, 533, 582, 640, 711, 800,
                           853, 914, 985, 1067, 1164, 1280, 1422, 1600};

    always #2 clk = ~clk;

    cpu_clk_stepper u_cpu_clk_stepper (
        .clk_master (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
        .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
        .cpu_clk (cpu_clk), .fast_mode (fast_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic port_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        io_addr = addr; io_wdata = data; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic port_read(input logic [7:0] addr, input logic rd, output logic [7:0] data);
        io_addr = addr; io_rd = rd;
        #1 data = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic wait_rise();
        logic prev;
        prev = cpu_clk;
        forever begin
            @(negedge clk);
            if (!prev && cpu_clk) break;
            prev = cpu_clk;
        end
    endtask

    // Starts on the first sample of a period; ends on the first sample of the next one.
    task automatic measure(output int len, output int hi);
        logic prev;
        len = 1; hi = 1; prev = cpu_clk;
        forever begin
            @(negedge clk);
            if (!prev && cpu_clk) break;
            len++;
            if (cpu_clk) hi++;
            prev = cpu_clk;
        end
    endtask

    task automatic t_reset();
        logic [7:0] rd;
        int len, hi;
        check(cpu_clk == 1'b1, "R1 clk high in reset", cpu_clk, 1);
        check(fast_mode == 1'b0, "R1 fast low in reset", fast_mode, 0);
        @(negedge clk); rst_n = 1'b1;
        port_read(8'hFF, 1'b1, rd);
        check(rd == 8'h00, "R1 code zero after reset", rd, 0);
        measure(len, hi);
        check(len == 8, "R1 first period length", len, 8);
        check(hi == 4, "R1 first period high", hi, 4);
    endtask

    task automatic t_port_access();
        logic [7:0] rd;
        int len, hi;
        port_write(8'hFE, 8'hA0);
        port_read(8'hFF, 1'b1, rd);
        check(rd == 8'h00, "R2 write to other address ignored", rd, 0);
        check(fast_mode == 1'b0, "R2 fast unchanged by other address", fast_mode, 0);
        wait_rise(); measure(len, hi);
        check(len == 8, "R2 period unchanged by other address", len, 8);
        port_write(8'hFF, 8'h7A);
        port_read(8'hFF, 1'b1, rd);
        check(rd == 8'h70, "R3 readback low nibble zero", rd, 8'h70);
        port_read(8'hFF, 1'b0, rd);
        check(rd == 8'h00, "R3 no read strobe gives zero", rd, 0);
        port_read(8'h3C, 1'b1, rd);
        check(rd == 8'h00, "R3 other address reads zero", rd, 0);
    endtask

    task automatic t_sweep();
        logic [7:0] rd;
        int d, r, exp_len, len, hi, sum4;
        for (int code = 0; code < 16; code++) begin
            d = (12800 + freq_x100[code] / 2) / freq_x100[code];
            port_write(8'hFF, 8'(code << 4));
            check(fast_mode == (code != 0), $sformatf("R8 fast flag code %0d", code),
                  fast_mode, code != 0);
            port_read(8'hFF, 1'b1, rd);
            check(rd == 8'(code << 4), $sformatf("R3 readback code %0d", code), rd, code << 4);
            wait_rise();
            r = 0; sum4 = 0;
            for (int p = 0; p < 8; p++) begin
                exp_len = (r + d) / 4;
                r = (r + d) % 4;
                measure(len, hi);
                check(len == exp_len, $sformatf("R4 R5 code %0d period %0d length", code, p),
                      len, exp_len);
                check(hi == exp_len / 2, $sformatf("R6 code %0d period %0d high", code, p),
                      hi, exp_len / 2);
                if (p < 4) sum4 += len;
            end
            check(sum4 == d, $sformatf("R9 code %0d four-period sum", code), sum4, d);
        end
    endtask

    task automatic t_mid_switch();
        logic prev;
        int len, hi;
        port_write(8'hFF, 8'h00);
        wait_rise(); wait_rise();
        len = 1; hi = 1; prev = cpu_clk;
        io_addr = 8'hFF; io_wdata = 8'hF0; io_wr = 1'b1;
        forever begin
            @(negedge clk);
            io_wr = 1'b0;
            if (!prev && cpu_clk) break;
            len++;
            if (cpu_clk) hi++;
            prev = cpu_clk;
        end
        check(len == 8, "R7 period in progress keeps old length", len, 8);
        check(hi == 4, "R7 period in progress keeps old high", hi, 4);
        measure(len, hi);
        check(len == 2, "R7 new code applied at next period", len, 2);
        check(hi == 1, "R6 fastest period high for one cycle", hi, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_port_access();
        t_sweep();
        t_mid_switch();
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule